// File: doc/BRIEF.md
# I2C Clock Phase Timer

This block produces the serial clock of an I2C master together with two single-cycle strobes that pace the data line: one marks the moment the data line may be changed for the next bit, the other marks the moment the data line should be captured. A byte shifter elsewhere uses these strobes. The timer does not decode commands and does not control the frequency of its input clock.

Time is counted in ticks. A prescaler divides the system clock, and an optional second divider divides it further. Each bit period is split into three phases: SCL low until it rises (setup), SCL high, and SCL low after it falls until the period ends (hold). In the fast mode, used for high-speed transfers, the three phase lengths come from three independent fields of one timing word, and a separate bit turns the mode on. In standard mode all three phases take their length from a single coefficient. Both timing words are captured only at the start of each bit period. So software may rewrite them at any time, and a bit that is already running is never distorted.

While `run_i` is low the timer idles with SCL released high. When `run_i` goes high the timer starts a bit period at once, and it then produces bit periods back to back until `run_i` drops.

Top module: `scl_phase_timer`

## Requirements
- R1: During reset, and in every cycle after a clock edge at which `run_i` was low, `scl_o` is 1 and both strobes are 0.
- R2: One tick lasts (P+1)*(D+1) clock cycles. P is the prescale field (bits 8:6 of `std_cfg_i`) and D is the post-divider field (bits 1:0), when the bypass bit (bit 2) is 0.
- R3: When the bypass bit (bit 2 of `std_cfg_i`) is 1, the post-divider field has no effect and one tick lasts P+1 clock cycles.
- R4: When bit 15 of `hs_cfg_i` is 1, the setup phase lasts bits 4:0 ticks, the high phase lasts bits 9:5 ticks and the hold phase lasts bits 14:10 ticks. SCL is low in setup and hold, and high in the high phase.
- R5: When bit 15 of `hs_cfg_i` is 0, each of the three phases lasts C+1 ticks, where C is bits 5:3 of `std_cfg_i`. The other fields of `hs_cfg_i` have no effect.
- R6: A fast-mode phase field of 0 gives a phase of 1 tick.
- R7: `sda_shift_o` is high for exactly one cycle: the first cycle of each setup phase.
- R8: `sda_sample_o` is high for exactly one cycle, floor(H/2) ticks after the high phase begins, where H is the length of the high phase in ticks.
- R9: A value written to either timing word while a bit is in progress takes effect only from the start of the next bit period. This covers the dividers as well as the phase lengths.
- R10: At a clock edge where `run_i` is 1 and the timer is idle, a new bit period begins, so the next cycle is the first cycle of a setup phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Produce bit periods while high |
| std_cfg_i | input | 16 | Standard timing word: divider, bypass, coefficient, prescale |
| hs_cfg_i | input | 16 | Fast-mode timing word: setup, high, hold, mode enable |
| scl_o | output | 1 | Serial clock level to drive (1 = released) |
| sda_shift_o | output | 1 | One-cycle strobe: data line may change |
| sda_sample_o | output | 1 | One-cycle strobe: capture the data line |

## Verification
The bench rewrites both timing words in the middle of a bit. A design that applies the new values at once would shorten or stretch the current phase, or would change the tick rate in the middle of a phase. The bench sets the bypass bit together with a non-zero post-divider, where a design that still applied the divider would run slow. It also uses zero-length fast-mode fields, where a design without the one-tick minimum would wrap its counter and stall for 32 ticks. High phases of odd and of one-tick length check the placement of the sample strobe. Dropping and raising `run_i` in the middle of a bit checks that the timer returns to idle cleanly and restarts with a fresh setup phase.

// File: rtl/scl_timer_pkg.sv
package scl_timer_pkg;

  parameter int REG_W   = 16;
  parameter int FIELD_W = 5;
  parameter int PRE_W   = 3;
  parameter int DIV_W   = 2;
  parameter int COEF_W  = 3;

  // Bit positions within the timing words
  localparam int HS_SETUP_LSB = 0;
  localparam int HS_HIGH_LSB  = HS_SETUP_LSB + FIELD_W;
  localparam int HS_HOLD_LSB  = HS_HIGH_LSB + FIELD_W;
  localparam int HS_MODE_BIT  = 15;
  localparam int STD_DIV_LSB  = 0;
  localparam int STD_BYP_BIT  = STD_DIV_LSB + DIV_W;
  localparam int STD_COEF_LSB = STD_BYP_BIT + 1;
  localparam int STD_PRE_LSB  = STD_COEF_LSB + COEF_W;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_HIGH  = 2'd2,
    PH_HOLD  = 2'd3
  } phase_e;

  typedef struct packed {
    logic [PRE_W-1:0]   pre;
    logic [DIV_W-1:0]   div;
    logic               bypass;
    logic [FIELD_W-1:0] len_setup;
    logic [FIELD_W-1:0] len_high;
    logic [FIELD_W-1:0] len_hold;
  } timing_t;

endpackage

// File: rtl/scl_cfg_decode.sv
module scl_cfg_decode
  import scl_timer_pkg::*;
(
  input  logic [REG_W-1:0] std_cfg_i,
  input  logic [REG_W-1:0] hs_cfg_i,
  output timing_t          timing_o
);

  logic [FIELD_W-1:0] std_len;
  logic [FIELD_W-1:0] raw_len [3];
  logic [FIELD_W-1:0] min_len [3];
  logic               fast_mode;

  assign fast_mode = hs_cfg_i[HS_MODE_BIT];
  assign std_len   = FIELD_W'(std_cfg_i[STD_COEF_LSB +: COEF_W]) + FIELD_W'(1);

  // Index 0 = setup, 1 = high, 2 = hold; fields are packed contiguously
  for (genvar g = 0; g < 3; g++) begin : g_field
    assign raw_len[g] = hs_cfg_i[HS_SETUP_LSB + g*FIELD_W +: FIELD_W];
    assign min_len[g] = (raw_len[g] == '0) ? FIELD_W'(1) : raw_len[g];
  end

  always_comb begin
    timing_o.pre       = std_cfg_i[STD_PRE_LSB +: PRE_W];
    timing_o.div       = std_cfg_i[STD_DIV_LSB +: DIV_W];
    timing_o.bypass    = std_cfg_i[STD_BYP_BIT];
    timing_o.len_setup = fast_mode ? min_len[0] : std_len;
    timing_o.len_high  = fast_mode ? min_len[1] : std_len;
    timing_o.len_hold  = fast_mode ? min_len[2] : std_len;
  end

endmodule

// File: rtl/scl_tick_gen.sv
module scl_tick_gen
  import scl_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [PRE_W-1:0] pre_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             bypass_i,
  output logic             tick_o
);

  logic [PRE_W-1:0] pcnt_q, pcnt_d;
  logic [DIV_W-1:0] dcnt_q, dcnt_d;
  logic             pre_hit;
  logic             div_hit;

  assign pre_hit = en_i && (pcnt_q == pre_i);
  assign div_hit = bypass_i || (dcnt_q == div_i);
  assign tick_o  = pre_hit && div_hit;

  always_comb begin
    pcnt_d = pcnt_q;
    dcnt_d = dcnt_q;
    if (!en_i) begin
      pcnt_d = '0;
      dcnt_d = '0;
    end else if (pre_hit) begin
      pcnt_d = '0;
      dcnt_d = div_hit ? '0 : dcnt_q + DIV_W'(1);
    end else begin
      pcnt_d = pcnt_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      dcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_d;
      dcnt_q <= dcnt_d;
    end
  end

endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
  import scl_timer_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    run_i,
  input  logic    tick_i,
  input  timing_t timing_i,
  output timing_t timing_q_o,
  output phase_e  phase_o,
  output logic    shift_o,
  output logic    sample_o
);

  phase_e             ph_q, ph_d;
  logic [FIELD_W-1:0] cnt_q, cnt_d;
  timing_t            cfg_q, cfg_d;
  logic               shift_q, shift_d;
  logic               sample_q, sample_d;
  logic [FIELD_W-1:0] cur_len;
  logic [FIELD_W-1:0] half_high;
  logic [FIELD_W-1:0] cnt_inc;

  assign half_high = cfg_q.len_high >> 1;
  assign cnt_inc   = cnt_q + FIELD_W'(1);

  always_comb begin
    case (ph_q)
      PH_SETUP: cur_len = cfg_q.len_setup;
      PH_HIGH:  cur_len = cfg_q.len_high;
      PH_HOLD:  cur_len = cfg_q.len_hold;
      default:  cur_len = FIELD_W'(1);
    endcase
  end

  always_comb begin
    ph_d     = ph_q;
    cnt_d    = cnt_q;
    cfg_d    = cfg_q;
    shift_d  = 1'b0;
    sample_d = 1'b0;
    if (!run_i) begin
      ph_d  = PH_IDLE;
      cnt_d = '0;
    end else if (ph_q == PH_IDLE) begin
      ph_d    = PH_SETUP;
      cnt_d   = '0;
      cfg_d   = timing_i;
      shift_d = 1'b1;
    end else if (tick_i) begin
      if (cnt_inc == cur_len) begin
        cnt_d = '0;
        case (ph_q)
          PH_SETUP: begin
            ph_d     = PH_HIGH;
            sample_d = (half_high == '0);
          end
          PH_HIGH:  ph_d = PH_HOLD;
          default: begin
            ph_d    = PH_SETUP;
            cfg_d   = timing_i;
            shift_d = 1'b1;
          end
        endcase
      end else begin
        cnt_d    = cnt_inc;
        sample_d = (ph_q == PH_HIGH) && (cnt_inc == half_high);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_IDLE;
      cnt_q    <= '0;
      cfg_q    <= '0;
      shift_q  <= 1'b0;
      sample_q <= 1'b0;
    end else begin
      ph_q     <= ph_d;
      cnt_q    <= cnt_d;
      cfg_q    <= cfg_d;
      shift_q  <= shift_d;
      sample_q <= sample_d;
    end
  end

  assign timing_q_o = cfg_q;
  assign phase_o    = ph_q;
  assign shift_o    = shift_q;
  assign sample_o   = sample_q;

endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer
  import scl_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [REG_W-1:0] std_cfg_i,
  input  logic [REG_W-1:0] hs_cfg_i,
  output logic             scl_o,
  output logic             sda_shift_o,
  output logic             sda_sample_o
);

  timing_t timing_new;
  timing_t cfg_q;
  phase_e  phase;
  logic    tick;

  scl_cfg_decode u_decode (
    .std_cfg_i (std_cfg_i),
    .hs_cfg_i  (hs_cfg_i),
    .timing_o  (timing_new)
  );

  scl_phase_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run_i),
    .tick_i     (tick),
    .timing_i   (timing_new),
    .timing_q_o (cfg_q),
    .phase_o    (phase),
    .shift_o    (sda_shift_o),
    .sample_o   (sda_sample_o)
  );

  scl_tick_gen u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (phase != PH_IDLE),
    .pre_i    (cfg_q.pre),
    .div_i    (cfg_q.div),
    .bypass_i (cfg_q.bypass),
    .tick_o   (tick)
  );

  assign scl_o = (phase == PH_IDLE) || (phase == PH_HIGH);

endmodule

// File: rtl/scl_phase_timer_chk.sv
module scl_phase_timer_chk
  import scl_timer_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input logic    run_i,
  input logic    scl_o,
  input logic    sda_shift_o,
  input logic    sda_sample_o,
  input timing_t cfg_q
);

  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (scl_o && !sda_shift_o && !sda_sample_o));

  a_r7_shift_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    sda_shift_o |-> !scl_o);

  a_r8_sample_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    sda_sample_o |-> scl_o);

  a_r8_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(sda_shift_o && sda_sample_o));

  a_r9_cfg_held_in_bit: assert property (@(posedge clk) disable iff (!rst_n)
    !sda_shift_o |-> $stable(cfg_q));

  a_r10_start_on_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_i) |=> sda_shift_o);

endmodule

bind scl_phase_timer scl_phase_timer_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .run_i        (run_i),
  .scl_o        (scl_o),
  .sda_shift_o  (sda_shift_o),
  .sda_sample_o (sda_sample_o),
  .cfg_q        (cfg_q)
);

// File: tb/scl_phase_timer_tb.sv
module scl_phase_timer_tb;

  logic        clk;
  logic        rst_n;
  logic        run_i;
  logic [15:0] std_cfg_i;
  logic [15:0] hs_cfg_i;
  logic        scl_o;
  logic        sda_shift_o;
  logic        sda_sample_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  scl_phase_timer u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_i        (run_i),
    .std_cfg_i    (std_cfg_i),
    .hs_cfg_i     (hs_cfg_i),
    .scl_o        (scl_o),
    .sda_shift_o  (sda_shift_o),
    .sda_sample_o (sda_sample_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Reference model: position k within the current bit, in clock cycles
  bit m_active;
  int k, t_len, ls, lh, ld, period;

  function automatic int fld(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic load_cfg();
    int pre, dv, byp, coef;
    pre  = (std_cfg_i >> 6) & 7;
    coef = (std_cfg_i >> 3) & 7;
    byp  = (std_cfg_i >> 2) & 1;
    dv   = std_cfg_i & 3;
    t_len = (pre + 1) * (byp ? 1 : dv + 1);
    if (hs_cfg_i[15]) begin
      ls = fld(hs_cfg_i & 31);
      lh = fld((hs_cfg_i >> 5) & 31);
      ld = fld((hs_cfg_i >> 10) & 31);
    end else begin
      ls = coef + 1; lh = coef + 1; ld = coef + 1;
    end
    period = (ls + lh + ld) * t_len;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_active = 0;
      k = 0;
    end else if (!run_i) begin
      m_active = 0;
    end else if (!m_active) begin
      m_active = 1;
      k = 0;
      load_cfg();
    end else begin
      k++;
      if (k == period) begin
        k = 0;
        load_cfg();
      end
    end
  end

  task automatic compare(input string tag);
    bit e_scl, e_sh, e_sm;
    if (!m_active) begin
      e_scl = 1; e_sh = 0; e_sm = 0;
    end else begin
      e_scl = (k >= ls * t_len) && (k < (ls + lh) * t_len);
      e_sh  = (k == 0);
      e_sm  = (k == (ls + lh / 2) * t_len);
    end
    checks++;
    if (scl_o !== e_scl || sda_shift_o !== e_sh || sda_sample_o !== e_sm) begin
      failures++;
      $display("FAIL %s: scl/shift/sample actual=%b%b%b expected=%b%b%b (k=%0d)",
               tag, scl_o, sda_shift_o, sda_sample_o, e_scl, e_sh, e_sm, k);
    end
  endtask

  task automatic step(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare(tag);
    end
  endtask

  function automatic logic [15:0] hsw(input int mode, input int su, input int hi, input int ho);
    return 16'((mode << 15) | (ho << 10) | (hi << 5) | su);
  endfunction

  function automatic logic [15:0] stdw(input int pre, input int coef, input int byp, input int dv);
    return 16'((pre << 6) | (coef << 3) | (byp << 2) | dv);
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; run_i = 1'b0; std_cfg_i = '0; hs_cfg_i = '0;
    step(3, "R1 in reset");
    rst_n = 1'b1;
    step(5, "R1 idle");

    // R4 R7 R8: typical fast-mode setting, tick = 2 clocks
    std_cfg_i = stdw(1, 0, 0, 0);
    hs_cfg_i  = hsw(1, 20, 8, 1);
    run_i = 1'b1;
    step(200, "R4 R7 R8 fast mode");
    run_i = 1'b0;
    step(4, "R1 after stop");

    // R2 R5: standard mode, prescale 2, divider 2, coef 1; fast fields ignored
    std_cfg_i = stdw(2, 1, 0, 2);
    hs_cfg_i  = hsw(0, 3, 9, 4);
    run_i = 1'b1;
    step(170, "R2 R5 standard mode");

    // R3: bypass with non-zero divider (R9: takes effect at next bit)
    std_cfg_i = stdw(1, 2, 1, 3);
    step(150, "R3 R9 bypass divider");
    run_i = 1'b0;
    step(3, "R1 idle");

    // R6: zero fast fields, one-clock ticks
    std_cfg_i = stdw(0, 0, 1, 0);
    hs_cfg_i  = hsw(1, 0, 0, 0);
    run_i = 1'b1;
    step(30, "R6 zero fields");

    // R8: odd high phase, R9: rewrite both words mid-bit
    hs_cfg_i = hsw(1, 2, 7, 3);
    step(40, "R8 odd high");
    std_cfg_i = stdw(1, 0, 0, 1);
    hs_cfg_i  = hsw(1, 5, 1, 2);
    step(7, "R9 mid-bit rewrite");
    hs_cfg_i  = hsw(1, 1, 5, 1);
    step(120, "R9 mid-bit rewrite");

    // R10: drop run mid-bit, restart
    run_i = 1'b0;
    step(2, "R10 drop");
    run_i = 1'b1;
    step(13, "R10 restart");
    run_i = 1'b0;
    step(1, "R10 drop");
    run_i = 1'b1;
    step(60, "R10 quick restart");
    run_i = 1'b0;
    step(4, "R1 final idle");

    finish_run();
  end

endmodule